// File: doc/BRIEF.md
# Prescaled Dual Timer with Watchdog

This peripheral holds one programmable prescaler, two general-purpose down-counters and a watchdog counter. The prescaler counts down from its reload value. When it passes zero it produces a one-cycle tick, and that tick advances both timers and the watchdog. Each timer runs in periodic mode or in one-shot mode, and each timer has its own interrupt line that pulses for one cycle when the timer underflows.

The watchdog counts down on every tick and stops at zero. While it sits at zero, the active-low output `wdog_n` is asserted. System logic can use that output as a reset request. Software keeps the system alive by writing the watchdog register, which reloads the counter. All registers are reached through a simple synchronous write port and a combinational read port.

Register map (word addresses):
- 0: prescaler reload (read/write).
- 1: prescaler count (read only).
- 2, 3, 4: timer A reload, count (read only) and control.
- 5, 6, 7: timer B reload, count (read only) and control.
- 8: watchdog count. A write loads it.

Control register fields:
- Bit 0 is the enable.
- Bit 1 selects the mode: 1 for periodic, 0 for one-shot.
- Bit 2 is the load strobe. It always reads as 0.

Top module: `tick_timer_wdt`

## Requirements
- R1: After reset the prescaler reload reads all ones, both timer reloads, counts and controls read 0, the watchdog count reads all ones, and `wdog_n` is high.
- R2: The prescaler count decrements by one per clock. In the cycle it holds 0 it emits a tick and then reloads, so ticks repeat every reload+1 cycles. Writing address 0 sets both the reload and the count to the written value.
- R3: An enabled periodic timer (control bit 1 = 1) decrements once per tick. On a tick while its count is 0, it reloads and pulses its `irq` bit high for exactly one cycle. Pulses repeat every (reload+1)*(prescaler reload+1) cycles.
- R4: An enabled one-shot timer (control bit 1 = 0) that underflows pulses its `irq` once. It then clears its enable bit and holds its count at 0.
- R5: Writing a control register with bit 2 set copies that timer's reload into its count at the same edge. A disabled timer holds its count.
- R6: The two timers run independently: timer A drives `irq[0]`, timer B drives `irq[1]`, each with its own period.
- R7: The watchdog count decrements once per tick and stays at 0 once it reaches 0. `wdog_n` is low exactly while the count is 0.
- R8: A write to address 8 loads the watchdog count with the written value, so a nonzero write drives `wdog_n` high from the next cycle.
- R9: Each register reads back at the address given in the register map, with unused upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable, sampled on the rising edge |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq | output | 2 | One-cycle underflow pulse per timer (bit 0 = timer A) |
| wdog_n | output | 1 | Active-low watchdog expiry |

## Verification
The bench uses a 6-bit prescaler, 12-bit timers and a 10-bit watchdog. With these widths the reset-time watchdog expiry, 1023 ticks of 64 cycles each, falls within a short run. The bench times that expiry to the exact cycle. Smaller reload values, written later, bring several periodic intervals of both timers, a one-shot underflow, a full prescaler wrap and the watchdog's service-and-expire sequence into a few hundred cycles.

// File: rtl/tick_timer_wdt.sv
module tick_timer_wdt #(
  parameter int PRE_W  = 10,
  parameter int CNT_W  = 24,
  parameter int WD_W   = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        irq,
  output logic              wdog_n
);
  localparam logic [ADDR_W-1:0] A_PRE_RLD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE_CNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_WD      = ADDR_W'(8);
  localparam int NT = 2;

  logic [PRE_W-1:0] pre_rld, pre_cnt;
  logic [WD_W-1:0]  wd_cnt;
  logic             tick;

  logic [CNT_W-1:0] t_rld [NT];
  logic [CNT_W-1:0] t_cnt [NT];
  logic             t_en  [NT];
  logic             t_per [NT];
  logic             t_irq [NT];

  assign tick = (pre_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_rld <= '1;
      pre_cnt <= '1;
    end else if (we && addr == A_PRE_RLD) begin
      pre_rld <= PRE_W'(wdata);
      pre_cnt <= PRE_W'(wdata);
    end else if (tick) begin
      pre_cnt <= pre_rld;
    end else begin
      pre_cnt <= pre_cnt - PRE_W'(1);
    end
  end

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(2 + 3 * k);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(4 + 3 * k);
    logic rld_wr, ctl_wr, uf;
    assign rld_wr = we && addr == A_RLD;
    assign ctl_wr = we && addr == A_CTL;
    assign uf     = tick && t_en[k] && t_cnt[k] == '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_rld[k] <= '0;
        t_cnt[k] <= '0;
        t_en[k]  <= 1'b0;
        t_per[k] <= 1'b0;
        t_irq[k] <= 1'b0;
      end else begin
        t_irq[k] <= uf;
        if (rld_wr) t_rld[k] <= CNT_W'(wdata);
        if (ctl_wr) begin
          t_en[k]  <= wdata[0];
          t_per[k] <= wdata[1];
        end else if (uf && !t_per[k]) begin
          t_en[k] <= 1'b0;
        end
        if (ctl_wr && wdata[2])     t_cnt[k] <= t_rld[k];
        else if (uf)                t_cnt[k] <= t_per[k] ? t_rld[k] : '0;
        else if (tick && t_en[k])   t_cnt[k] <= t_cnt[k] - CNT_W'(1);
      end
    end
  end

  assign irq = {t_irq[1], t_irq[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wd_cnt <= '1;
    else if (we && addr == A_WD)    wd_cnt <= WD_W'(wdata);
    else if (tick && wd_cnt != '0)  wd_cnt <= wd_cnt - WD_W'(1);
  end

  assign wdog_n = (wd_cnt != '0);

  always_comb begin
    rdata = '0;
    case (addr)
      A_PRE_RLD:   rdata = DATA_W'(pre_rld);
      A_PRE_CNT:   rdata = DATA_W'(pre_cnt);
      ADDR_W'(2):  rdata = DATA_W'(t_rld[0]);
      ADDR_W'(3):  rdata = DATA_W'(t_cnt[0]);
      ADDR_W'(4):  rdata = DATA_W'({t_per[0], t_en[0]});
      ADDR_W'(5):  rdata = DATA_W'(t_rld[1]);
      ADDR_W'(6):  rdata = DATA_W'(t_cnt[1]);
      ADDR_W'(7):  rdata = DATA_W'({t_per[1], t_en[1]});
      A_WD:        rdata = DATA_W'(wd_cnt);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_wdt_chk.sv
module tick_timer_wdt_chk #(
  parameter int PRE_W  = 10,
  parameter int CNT_W  = 24,
  parameter int WD_W   = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              we,
  input logic [1:0]        irq,
  input logic              wdog_n,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [WD_W-1:0]   wd_cnt,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  rld0,
  input logic              en0,
  input logic              per0
);
  logic pre_wr, ctl0_wr, wd_wr, uf0;
  assign pre_wr  = we && addr == ADDR_W'(0);
  assign ctl0_wr = we && addr == ADDR_W'(4);
  assign wd_wr   = we && addr == ADDR_W'(8);
  assign uf0     = pre_cnt == '0 && en0 && cnt0 == '0;

  a_r2_prescaler_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != '0 && !pre_wr) |=> pre_cnt == $past(pre_cnt) - PRE_W'(1));

  a_r3_irq_after_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> $past(uf0));

  a_r3_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf0 && per0 && !ctl0_wr) |=> cnt0 == $past(rld0));

  a_r4_oneshot_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (uf0 && !per0 && !ctl0_wr) |=> !en0 && cnt0 == '0);

  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_wr && wdata[2]) |=> cnt0 == $past(rld0));

  a_r7_wd_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cnt == '0 && !wd_wr) |=> wd_cnt == '0 && !wdog_n);

  a_r8_service_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wr && WD_W'(wdata) != '0) |=> wdog_n);
endmodule

bind tick_timer_wdt tick_timer_wdt_chk #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .WD_W(WD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .irq(irq), .wdog_n(wdog_n), .pre_cnt(pre_cnt), .wd_cnt(wd_cnt),
  .cnt0(t_cnt[0]), .rld0(t_rld[0]), .en0(t_en[0]), .per0(t_per[0])
);

// File: tb/test_tick_timer_wdt.sv
`timescale 1ns/1ps
module test_tick_timer_wdt;
  localparam int PRE_W = 6, CNT_W = 12, WD_W = 10, DATA_W = 32, ADDR_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic [1:0] irq;
  logic wdog_n;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  tick_timer_wdt #(.PRE_W(PRE_W), .CNT_W(CNT_W), .WD_W(WD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W))
    i_tick_timer_wdt (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
                      .rdata(rdata), .irq(irq), .wdog_n(wdog_n));

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = ADDR_W'(a); wdata = DATA_W'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); addr = ADDR_W'(a); #1 v = rdata;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    chk("R1 wdog_n", 32'(wdog_n), 1);
    rd(0, v); chk("R1 prescaler reload", v, 63);
    rd(2, v); chk("R1 timer A reload", v, 0);
    rd(3, v); chk("R1 timer A count", v, 0);
    rd(4, v); chk("R1 timer A control", v, 0);
    rd(7, v); chk("R1 timer B control", v, 0);
    rd(8, v); chk("R1 watchdog count", v, 1023);
    rd(9, v); chk("R9 unmapped address", v, 0);
  endtask

  task automatic t_wd_reset_expiry;
    while (wdog_n) @(negedge clk);
    chk("R7 cycles to expiry from reset", 32'(cyc), 64 * 1023);
  endtask

  task automatic t_prescaler;
    logic [31:0] v;
    wr(0, 5);
    for (int i = 0; i < 7; i++) begin
      rd(1, v); chk("R2 prescaler count", v, 32'((4 - i + 12) % 6));
    end
    rd(0, v); chk("R9 prescaler reload readback", v, 5);
  endtask

  task automatic t_load_hold;
    logic [31:0] v;
    wr(5, 9); wr(7, 4);
    rd(6, v); chk("R5 load copies reload", v, 9);
    repeat (40) @(negedge clk);
    rd(6, v); chk("R5 disabled timer holds", v, 9);
    rd(7, v); chk("R5 load bit reads 0", v, 0);
    chk("R5 no irq while disabled", 32'(irq[1]), 0);
  endtask

  task automatic t_periodic;
    int last[2], first[2], n[2], wide[2];
    logic prev[2];
    wr(0, 3); wr(2, 2); wr(5, 4); wr(4, 7); wr(7, 7);
    for (int k = 0; k < 2; k++) begin last[k] = -1; first[k] = 0; n[k] = 0; wide[k] = 0; prev[k] = 0; end
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        if (irq[k] && prev[k]) wide[k]++;
        if (irq[k] && !prev[k]) begin
          if (last[k] >= 0 && n[k] < 3) begin
            chk(k == 0 ? "R3 timer A period" : "R6 timer B period",
                32'(t - last[k]), k == 0 ? 12 : 20);
          end
          last[k] = t; n[k]++;
        end
        prev[k] = irq[k];
      end
    end
    chk("R3 irq A single-cycle", 32'(wide[0]), 0);
    chk("R6 irq B single-cycle", 32'(wide[1]), 0);
    wr(4, 0); wr(7, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int pulses = 0;
    wr(2, 3); wr(4, 5);
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (irq[0]) pulses++;
    end
    chk("R4 one-shot pulse count", 32'(pulses), 1);
    rd(4, v); chk("R4 enable cleared", v, 0);
    rd(3, v); chk("R4 count held at zero", v, 0);
  endtask

  task automatic t_wd_service;
    logic [31:0] v;
    int n = 0;
    wr(0, 3); wr(8, 5);
    chk("R8 wdog_n released after write", 32'(wdog_n), 1);
    while (wdog_n && n < 100) begin @(negedge clk); n++; end
    chk("R7 cycles to expiry after service", 32'(n), 18);
    repeat (30) @(negedge clk);
    rd(8, v); chk("R7 watchdog stays at zero", v, 0);
    chk("R7 wdog_n stays low", 32'(wdog_n), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_wd_reset_expiry;
    t_prescaler;
    t_load_hold;
    t_periodic;
    t_oneshot;
    t_wd_service;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule